// File: doc/BRIEF.md
# Dual Start-Stop Interval Counter

This block measures two time intervals at once, one per measurement ramp. Each channel counts cycles of a fixed reference clock. A channel starts on the rising edge of its start pulse and stops on the rising edge of its stop pulse. The stop pulse comes from a comparator that sees the ramp fall to a reference level. The start and stop inputs arrive without any timing relation to the reference clock. Each one passes through a two-flop synchronizer, and only its rising edge is used.

A host reads both 8-bit results and a status word over a small address-selected read port. It then decides which of the two measurements it trusts. A host clear returns both channels to their empty state, ready for the next pair of measurements.

Each channel is a three-state machine. IDLE moves to RUN on a start edge. RUN moves to HELD on a stop edge. A clear moves any state back to IDLE. HELD waits for that clear, and no other transition leaves it.

Top module: `dual_interval_counter`

## Requirements
- R1: After reset both counts are 0, every flag is 0, both channels are in IDLE, and every read address returns 0.
- R2: A channel in RUN adds one to its count on every reference clock edge, including the edge that sees the stop edge. The stored result therefore equals the number of reference clock periods between the synchronized rising edge of start and the synchronized rising edge of stop.
- R3: A count that reaches 255 stays at 255. In the same cycle, that channel's overflow flag sets and then stays set until a clear.
- R4: A stop edge in RUN moves the channel to HELD and sets its done flag. The count is frozen from then on. The status word at address 2 holds done A in bit 0, done B in bit 1, overflow A in bit 2 and overflow B in bit 3. Its upper bits are 0.
- R5: A start edge has no effect on a channel that is in RUN or HELD. The count keeps following the first start edge.
- R6: A stop edge has no effect on a channel that is in IDLE. Its done flag stays 0 and its count stays 0.
- R7: A host clear, sampled on a clock edge, sets both counts to 0, clears all four flags and returns both channels to IDLE. Clear takes priority over any start or stop edge in the same cycle.
- R8: When the read strobe is high, address 0 returns count A, address 1 returns count B, address 2 returns the status word and address 3 returns 0. When the read strobe is low, the read bus is 0.
- R9: The two channels are independent. Edges on one channel's inputs never change the other channel's count, state or flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_start_a | input | 1 | Asynchronous start pulse, channel A |
| meas_stop_a | input | 1 | Asynchronous stop pulse, channel A |
| meas_start_b | input | 1 | Asynchronous start pulse, channel B |
| meas_stop_b | input | 1 | Asynchronous stop pulse, channel B |
| host_clr | input | 1 | Synchronous clear of both channels |
| host_rd | input | 1 | Read strobe |
| host_addr | input | 2 | Read address |
| host_data | output | CNT_W | Read data, 0 when not strobed |

## Verification
The bench first checks the exact interval: a stop placed D cycles after its start must read back as D. A design that skips the increment on the stop edge would read D-1 instead. Near the limit, a 254-cycle and a 255-cycle interval are run side by side, and a 300-cycle interval is run as well. These show whether the overflow flag sets early or late, and whether the count wraps to a small value. A second start in RUN or HELD, a stop while IDLE, and overlapping intervals on both channels would show up as a restarted count, a false done flag or crosstalk between channels. A read with the strobe low, and a read of address 3, catch a bus that does not return to 0.

// File: rtl/dic_pkg.sv
`timescale 1ns/1ps
package dic_pkg;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_HELD = 2'd2
    } chan_state_t;

    localparam int NUM_CH = 2;

    localparam logic [1:0] ADDR_CNT_A  = 2'd0;
    localparam logic [1:0] ADDR_CNT_B  = 2'd1;
    localparam logic [1:0] ADDR_STATUS = 2'd2;

    localparam int STS_DONE_A = 0;
    localparam int STS_DONE_B = 1;
    localparam int STS_OVF_A  = 2;
    localparam int STS_OVF_B  = 3;
    localparam int STS_BITS   = 4;

endpackage

// File: rtl/dic_edge_sync.sv
`timescale 1ns/1ps
module dic_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/dic_channel.sv
`timescale 1ns/1ps
module dic_channel
    import dic_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             start_rise,
    input  logic             stop_rise,
    output logic [CNT_W-1:0] count_o,
    output logic             done_o,
    output logic             ovf_o
);

    localparam logic [CNT_W-1:0] CNT_MAX    = '1;
    localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_PRELIM = CNT_MAX - CNT_ONE;

    chan_state_t      state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic             done_q;
    logic             ovf_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = CH_IDLE;
        end else begin
            unique case (state_q)
                CH_IDLE: if (start_rise) state_d = CH_RUN;
                CH_RUN:  if (stop_rise)  state_d = CH_HELD;
                CH_HELD: state_d = CH_HELD;
                default: state_d = CH_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // outputs: count, done and overflow
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            done_q  <= 1'b0;
            ovf_q   <= 1'b0;
        end else if (clr) begin
            count_q <= '0;
            done_q  <= 1'b0;
            ovf_q   <= 1'b0;
        end else if (state_q == CH_RUN) begin
            if (count_q != CNT_MAX) begin
                count_q <= count_q + CNT_ONE;
                if (count_q == CNT_PRELIM) ovf_q <= 1'b1;
            end
            if (stop_rise) done_q <= 1'b1;
        end
    end

    assign count_o = count_q;
    assign done_o  = done_q;
    assign ovf_o   = ovf_q;

endmodule

// File: rtl/dic_read_port.sv
`timescale 1ns/1ps
module dic_read_port
    import dic_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    input  logic [CNT_W-1:0] cnt_a,
    input  logic [CNT_W-1:0] cnt_b,
    input  logic             done_a,
    input  logic             done_b,
    input  logic             ovf_a,
    input  logic             ovf_b,
    output logic [CNT_W-1:0] rd_data
);

    logic [CNT_W-1:0] status_word;

    always_comb begin
        status_word             = '0;
        status_word[STS_DONE_A] = done_a;
        status_word[STS_DONE_B] = done_b;
        status_word[STS_OVF_A]  = ovf_a;
        status_word[STS_OVF_B]  = ovf_b;
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (rd_addr)
                ADDR_CNT_A:  rd_data = cnt_a;
                ADDR_CNT_B:  rd_data = cnt_b;
                ADDR_STATUS: rd_data = status_word;
                default:     rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/dual_interval_counter.sv
`timescale 1ns/1ps
module dual_interval_counter
    import dic_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_start_a,
    input  logic             meas_stop_a,
    input  logic             meas_start_b,
    input  logic             meas_stop_b,
    input  logic             host_clr,
    input  logic             host_rd,
    input  logic [1:0]       host_addr,
    output logic [CNT_W-1:0] host_data
);

    logic [NUM_CH-1:0] start_raw, stop_raw;
    logic [NUM_CH-1:0] start_rise, stop_rise;
    logic [NUM_CH-1:0] done_v, ovf_v;
    logic [CNT_W-1:0]  cnt_v [NUM_CH];

    logic [CNT_W-1:0]  cnt_a, cnt_b;
    logic              done_a, done_b, ovf_a, ovf_b;

    assign start_raw = {meas_start_b, meas_start_a};
    assign stop_raw  = {meas_stop_b,  meas_stop_a};

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        dic_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_start (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (start_raw[ch]),
            .rise_o   (start_rise[ch])
        );
        dic_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_stop (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (stop_raw[ch]),
            .rise_o   (stop_rise[ch])
        );
        dic_channel #(.CNT_W(CNT_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (host_clr),
            .start_rise (start_rise[ch]),
            .stop_rise  (stop_rise[ch]),
            .count_o    (cnt_v[ch]),
            .done_o     (done_v[ch]),
            .ovf_o      (ovf_v[ch])
        );
    end

    assign cnt_a  = cnt_v[0];
    assign cnt_b  = cnt_v[1];
    assign done_a = done_v[0];
    assign done_b = done_v[1];
    assign ovf_a  = ovf_v[0];
    assign ovf_b  = ovf_v[1];

    dic_read_port #(.CNT_W(CNT_W)) u_rd (
        .rd_en   (host_rd),
        .rd_addr (host_addr),
        .cnt_a   (cnt_a),
        .cnt_b   (cnt_b),
        .done_a  (done_a),
        .done_b  (done_b),
        .ovf_a   (ovf_a),
        .ovf_b   (ovf_b),
        .rd_data (host_data)
    );

endmodule

// File: rtl/dic_checker.sv
`timescale 1ns/1ps
module dic_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_clr,
    input logic             host_rd,
    input logic [CNT_W-1:0] host_data,
    input logic [CNT_W-1:0] cnt_a,
    input logic [CNT_W-1:0] cnt_b,
    input logic             done_a,
    input logic             done_b,
    input logic             ovf_a,
    input logic             ovf_b
);

    AST_STEP_A: assert property (@(posedge clk) disable iff (!rst_n)
        !host_clr |=> (cnt_a == $past(cnt_a) || cnt_a == $past(cnt_a) + CNT_W'(1))); // R2
    AST_STEP_B: assert property (@(posedge clk) disable iff (!rst_n)
        !host_clr |=> (cnt_b == $past(cnt_b) || cnt_b == $past(cnt_b) + CNT_W'(1))); // R9
    AST_OVF_SAT_A: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_a |-> cnt_a == '1); // R3
    AST_OVF_SAT_B: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_b |-> cnt_b == '1); // R3
    AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done_a && !host_clr) |=> (done_a && $stable(cnt_a))); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_b && !host_clr) |=> ovf_b); // R3
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        host_clr |=> (cnt_a == '0 && cnt_b == '0 && !done_a && !done_b && !ovf_a && !ovf_b)); // R7
    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |-> host_data == '0); // R8

endmodule

bind dual_interval_counter dic_checker #(.CNT_W(CNT_W)) u_dic_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_clr  (host_clr),
    .host_rd   (host_rd),
    .host_data (host_data),
    .cnt_a     (cnt_a),
    .cnt_b     (cnt_b),
    .done_a    (done_a),
    .done_b    (done_b),
    .ovf_a     (ovf_a),
    .ovf_b     (ovf_b)
);

// File: tb/test_dual_interval_counter.sv
`timescale 1ns/1ps
module test_dual_interval_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       meas_start_a = 1'b0, meas_stop_a = 1'b0;
    logic       meas_start_b = 1'b0, meas_stop_b = 1'b0;
    logic       host_clr = 1'b0, host_rd = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_data;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    dual_interval_counter i_dual_interval_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .meas_start_a (meas_start_a),
        .meas_stop_a  (meas_stop_a),
        .meas_start_b (meas_start_b),
        .meas_stop_b  (meas_stop_b),
        .host_clr     (host_clr),
        .host_rd      (host_rd),
        .host_addr    (host_addr),
        .host_data    (host_data)
    );

    // behavioural reference: input delay lines and per-channel interval state
    int  dly [4][3];
    int  m_phase [2];
    int  m_cnt   [2];
    bit  m_done  [2];
    bit  m_ovf   [2];

    function automatic int pin_val(int k);
        case (k)
            0: return int'(meas_start_a);
            1: return int'(meas_stop_a);
            2: return int'(meas_start_b);
            default: return int'(meas_stop_b);
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (dly[k, j]) dly[k][j] = 0;
            for (int c = 0; c < 2; c++) begin
                m_phase[c] = 0; m_cnt[c] = 0; m_done[c] = 0; m_ovf[c] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                bit go, halt;
                go   = (dly[2*c][1] == 1) && (dly[2*c][2] == 0);
                halt = (dly[2*c+1][1] == 1) && (dly[2*c+1][2] == 0);
                if (host_clr) begin
                    m_phase[c] = 0; m_cnt[c] = 0; m_done[c] = 0; m_ovf[c] = 0;
                end else if (m_phase[c] == 0) begin
                    if (go) m_phase[c] = 1;
                end else if (m_phase[c] == 1) begin
                    if (m_cnt[c] < 255) m_cnt[c]++;
                    if (m_cnt[c] == 255) m_ovf[c] = 1;
                    if (halt) begin m_phase[c] = 2; m_done[c] = 1; end
                end
            end
            for (int k = 0; k < 4; k++) begin
                dly[k][2] = dly[k][1];
                dly[k][1] = dly[k][0];
                dly[k][0] = pin_val(k);
            end
        end
    end

    function automatic logic [7:0] model_read();
        if (!host_rd) return 8'h00;
        case (host_addr)
            2'd0: return 8'(m_cnt[0]);
            2'd1: return 8'(m_cnt[1]);
            2'd2: return {4'h0, m_ovf[1], m_ovf[0], m_done[1], m_done[0]};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the model (R2 R8)
    always @(negedge clk) begin
        #1;
        if (rst_n) check(host_data, model_read(), "R2 R8 cycle model");
    end

    task automatic read_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #2;
        check(host_data, exp, tag);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); host_clr = 1'b1;
        @(negedge clk); host_clr = 1'b0;
    endtask

    function automatic bit on(int at, int i);
        return (at >= 0) && (i == at || i == at + 1);
    endfunction

    // two-cycle pulses at given cycle offsets; -1 means no pulse
    task automatic run_pulses(input int sa, input int sa2, input int pa,
                              input int sb, input int pb, input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            meas_start_a = on(sa, i) || on(sa2, i);
            meas_stop_a  = on(pa, i);
            meas_start_b = on(sb, i);
            meas_stop_b  = on(pb, i);
        end
        @(negedge clk);
        meas_start_a = 0; meas_stop_a = 0; meas_start_b = 0; meas_stop_b = 0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        read_chk(2'd0, 8'd0, "R1 count A after reset");
        read_chk(2'd1, 8'd0, "R1 count B after reset");
        read_chk(2'd2, 8'd0, "R1 status after reset");

        // R2 R9 overlapping intervals of different length
        run_pulses(0, -1, 10, 3, 40, 50);
        read_chk(2'd0, 8'd10, "R2 count A interval 10");
        read_chk(2'd1, 8'd37, "R9 count B interval 37");
        read_chk(2'd2, 8'h03, "R4 both done");

        // R5 start while held ignored
        run_pulses(0, -1, -1, 0, -1, 10);
        read_chk(2'd0, 8'd10, "R5 count A unchanged after start in HELD");
        read_chk(2'd2, 8'h03, "R5 status unchanged");

        // R7 clear
        pulse_clr();
        read_chk(2'd0, 8'd0, "R7 count A cleared");
        read_chk(2'd1, 8'd0, "R7 count B cleared");
        read_chk(2'd2, 8'd0, "R7 flags cleared");

        // R6 stop while idle ignored
        run_pulses(-1, -1, 2, -1, 2, 10);
        read_chk(2'd2, 8'd0, "R6 no done after idle stop");
        read_chk(2'd0, 8'd0, "R6 count A still zero");

        // R5 second start in RUN ignored
        run_pulses(0, 8, 20, 0, 15, 30);
        read_chk(2'd0, 8'd20, "R5 count A follows first start");
        read_chk(2'd1, 8'd15, "R9 count B interval 15");

        // R3 saturation on a 300-cycle interval, B never stops
        pulse_clr();
        run_pulses(0, -1, 300, 0, -1, 305);
        read_chk(2'd0, 8'd255, "R3 count A saturates");
        read_chk(2'd1, 8'd255, "R3 count B saturates while running");
        read_chk(2'd2, 8'h0D, "R3 overflow flags and done A");

        // R3 boundary: 255 overflows, 254 does not
        pulse_clr();
        run_pulses(0, -1, 255, 0, 254, 260);
        read_chk(2'd0, 8'd255, "R3 count A interval 255");
        read_chk(2'd1, 8'd254, "R3 count B interval 254");
        read_chk(2'd2, 8'h07, "R3 overflow only on A");

        // R8 bus quiet and unused address
        @(negedge clk);
        host_rd = 1'b0; host_addr = 2'd0;
        #2;
        check(host_data, 8'd0, "R8 no strobe drives zero");
        read_chk(2'd3, 8'd0, "R8 address 3 reads zero");

        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule